// File: doc/BRIEF.md
# Edge and Level Interrupt Collector

This block gathers up to 32 interrupt lines into two request outputs and one wake output. Each line has a 3-bit trigger code that makes it fire on a rising edge, a falling edge, either edge, a high level or a low level, or turns it off. Each line also has a mask bit, a wake bit, a route bit that picks one of the two request outputs, and a select bit that picks one of two physical inputs for the line. Before any of this, the chosen input goes through a two-flop synchroniser.

Software works on the state through a single-cycle register port. Every stored word has three addresses. Writing to the set address ORs the data into the word. Writing to the clear address removes the data bits from the word. The read address returns the word. Edge events are kept in two latch words, one for rising and one for falling, and software clears them through their own clear addresses. Two read-only pending words show which active, unmasked lines are routed to each request.

The register port has no handshake. A write is accepted in the cycle that `bus_wr_i` is high, and read data is a combinational function of the address. The port therefore never stalls the master, and the master never needs to stall the block.

Top module: `irq_edge_level_ctl`

## Requirements
- R1: Reset is synchronous and active high. After reset, the three config words, mask, wake and test words read 0. The route and select words read all ones. Both edge latches, both pending words and all three outputs are 0.
- R2: A bus address is `{index[3:0], op[1:0]}`. The op field is 0 for set, 1 for clear and 2 for read. The indices are: 0 config bit0, 1 config bit1, 2 config bit2, 3 mask, 4 wake, 5 route, 6 select, 7 test, 8 rise latch, 9 fall latch, 10 pending for request 0, 11 pending for request 1. A set write ORs the data into the word. A clear write removes the data bits. Zero data bits leave the stored bits unchanged. Writes to a read address have no effect. A read of any other address returns 0.
- R3: The trigger code of line i is {cfg2[i], cfg1[i], cfg0[i]}. Codes 000, 100 and 111 make the line inactive and never set its edge latches.
- R4: Code 001 latches a 0-to-1 change of the synchronised input. Code 010 latches a 1-to-0 change. Code 011 latches both changes, each in its own word. An edge-mode line is active while its enabled latch bit is set.
- R5: Code 101 makes the line active while its synchronised input is 1. Code 110 makes it active while the input is 0. Nothing is latched in either level mode.
- R6: A one written to the rise-clear or fall-clear address clears that latch bit, whatever the mask bit holds. If an edge arrives in the same cycle as the clear, the latch bit stays set.
- R7: A line appears in a pending word only while its mask bit is 1. Clearing the mask bit leaves the config words unchanged.
- R8: A line with route bit 1 appears in pending word 0 and drives `req0_o`. A line with route bit 0 appears in pending word 1 and drives `req1_o`.
- R9: Each request output is the OR of its pending word, registered once.
- R10: `wake_o` is the OR of the active lines that have their wake bit set, registered once. The mask bit has no effect on it.
- R11: A line with select bit 1 samples `irq_pri_i`. A line with select bit 0 samples `irq_alt_i`.
- R12: A level change on an input shows in the pending word after the second rising clock edge. An edge shows after the third. The request output follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | 6 | Register address: {index, op} |
| bus_wdata_i | input | 32 | Write data, one bit per line |
| bus_rdata_o | output | 32 | Read data for the current address |
| irq_pri_i | input | 32 | Primary interrupt inputs |
| irq_alt_i | input | 32 | Alternate interrupt inputs |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wake output |

## Verification
The assertions check on every cycle that:
- the request and wake outputs are the registered ORs of the pending and wake-qualified active words;
- no pending bit appears without its mask bit;
- no latch bit sets when its line's trigger code does not enable that edge;
- the outputs come out of reset low.

Some behaviour is visible only in the bench's scenarios, which compare against a cycle model:
- the exact synchroniser latency;
- an edge winning over a clear written in the same cycle;
- that undefined codes stay inactive;
- select-driven input swapping;
- the bit-exact effect of set and clear writes.

// File: rtl/iel_pkg.sv
package iel_pkg;

  // op field of a bus address
  localparam logic [1:0] OP_SET = 2'd0;
  localparam logic [1:0] OP_CLR = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;

  // word indices
  localparam int unsigned IDX_CFG0   = 0;
  localparam int unsigned IDX_CFG1   = 1;
  localparam int unsigned IDX_CFG2   = 2;
  localparam int unsigned IDX_MASK   = 3;
  localparam int unsigned IDX_WAKE   = 4;
  localparam int unsigned IDX_ROUTE  = 5;
  localparam int unsigned IDX_SELECT = 6;
  localparam int unsigned IDX_TEST   = 7;
  localparam int unsigned IDX_RISE   = 8;
  localparam int unsigned IDX_FALL   = 9;
  localparam int unsigned IDX_PEND0  = 10;
  localparam int unsigned IDX_PEND1  = 11;

  // number of words that are held in the set/clear bank
  localparam int unsigned NUM_STORE  = 8;

  // trigger codes {cfg2,cfg1,cfg0}
  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_FALL = 3'b010;
  localparam logic [2:0] TRIG_BOTH = 3'b011;
  localparam logic [2:0] TRIG_HIGH = 3'b101;
  localparam logic [2:0] TRIG_LOW  = 3'b110;

  // words that come out of reset with every bit set
  function automatic logic resets_to_ones(input int unsigned idx);
    return (idx == IDX_ROUTE) || (idx == IDX_SELECT);
  endfunction

endpackage

// File: rtl/iel_regbank.sv
module iel_regbank
  import iel_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned NSTORE = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_i,
  input  logic                         wr_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [1:0]                   op_i,
  input  logic [N-1:0]                 wdata_i,
  output logic [NSTORE-1:0][N-1:0]     words_o
);

  for (genvar k = 0; k < NSTORE; k++) begin : g_word
    localparam logic [N-1:0] RST_VAL = resets_to_ones(k) ? {N{1'b1}} : {N{1'b0}};
    logic hit;
    assign hit = wr_i && (idx_i == IDX_W'(k));

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        words_o[k] <= RST_VAL;
      end else if (hit && (op_i == OP_SET)) begin
        words_o[k] <= words_o[k] | wdata_i;
      end else if (hit && (op_i == OP_CLR)) begin
        words_o[k] <= words_o[k] & ~wdata_i;
      end
    end
  end

endmodule

// File: rtl/iel_sampler.sv
module iel_sampler #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] pri_i,
  input  logic [N-1:0] alt_i,
  input  logic [N-1:0] sel_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_ev_o,
  output logic [N-1:0] fall_ev_o
);

  logic [N-1:0] chosen;
  logic [N-1:0] meta_q;
  logic [N-1:0] prev_q;

  assign chosen = (pri_i & sel_i) | (alt_i & ~sel_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= '0;
      lvl_o  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= chosen;
      lvl_o  <= meta_q;
      prev_q <= lvl_o;
    end
  end

  assign rise_ev_o = lvl_o & ~prev_q;
  assign fall_ev_o = ~lvl_o & prev_q;

endmodule

// File: rtl/iel_event.sv
module iel_event
  import iel_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [N-1:0] cfg0_i,
  input  logic [N-1:0] cfg1_i,
  input  logic [N-1:0] cfg2_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] wake_i,
  input  logic [N-1:0] route_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] rise_ev_i,
  input  logic [N-1:0] fall_ev_i,
  input  logic [N-1:0] rise_clr_i,
  input  logic [N-1:0] fall_clr_i,
  output logic [N-1:0] rise_en_o,
  output logic [N-1:0] fall_en_o,
  output logic [N-1:0] rise_lat_o,
  output logic [N-1:0] fall_lat_o,
  output logic [N-1:0] active_o,
  output logic [N-1:0] pend0_o,
  output logic [N-1:0] pend1_o,
  output logic         req0_o,
  output logic         req1_o,
  output logic         wake_o
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [2:0] code;
    logic       hi_mode;
    logic       lo_mode;
    assign code         = {cfg2_i[i], cfg1_i[i], cfg0_i[i]};
    assign rise_en_o[i] = (code == TRIG_RISE) || (code == TRIG_BOTH);
    assign fall_en_o[i] = (code == TRIG_FALL) || (code == TRIG_BOTH);
    assign hi_mode      = (code == TRIG_HIGH);
    assign lo_mode      = (code == TRIG_LOW);
    assign active_o[i]  = (rise_en_o[i] & rise_lat_o[i])
                        | (fall_en_o[i] & fall_lat_o[i])
                        | (hi_mode & lvl_i[i])
                        | (lo_mode & ~lvl_i[i]);
  end

  // the event term is ORed in after the clear, so a same-cycle edge survives
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rise_lat_o <= '0;
      fall_lat_o <= '0;
    end else begin
      rise_lat_o <= (rise_lat_o & ~rise_clr_i) | (rise_ev_i & rise_en_o);
      fall_lat_o <= (fall_lat_o & ~fall_clr_i) | (fall_ev_i & fall_en_o);
    end
  end

  assign pend0_o = active_o & mask_i & route_i;
  assign pend1_o = active_o & mask_i & ~route_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      req0_o <= 1'b0;
      req1_o <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      req0_o <= |pend0_o;
      req1_o <= |pend1_o;
      wake_o <= |(active_o & wake_i);
    end
  end

endmodule

// File: rtl/irq_edge_level_ctl.sv
module irq_edge_level_ctl
  import iel_pkg::*;
#(
  parameter  int unsigned NUM_SRC = 32,
  parameter  int unsigned IDX_W   = 4,
  localparam int unsigned ADDR_W  = IDX_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [NUM_SRC-1:0] bus_wdata_i,
  output logic [NUM_SRC-1:0] bus_rdata_o,
  input  logic [NUM_SRC-1:0] irq_pri_i,
  input  logic [NUM_SRC-1:0] irq_alt_i,
  output logic               req0_o,
  output logic               req1_o,
  output logic               wake_o
);

  localparam int unsigned STORE_W = $clog2(NUM_STORE);

  logic [IDX_W-1:0] bus_idx;
  logic [1:0]       bus_op;
  assign bus_idx = bus_addr_i[ADDR_W-1:2];
  assign bus_op  = bus_addr_i[1:0];

  logic [NUM_STORE-1:0][NUM_SRC-1:0] store;
  logic [NUM_SRC-1:0] cfg0_w, cfg1_w, cfg2_w, mask_w, wake_w, route_w, select_w;
  logic [NUM_SRC-1:0] lvl, rise_ev, fall_ev, rise_clr, fall_clr;
  logic [NUM_SRC-1:0] rise_en, fall_en, rise_lat, fall_lat, active, pend0, pend1;

  iel_regbank #(.N(NUM_SRC), .IDX_W(IDX_W), .NSTORE(NUM_STORE)) u_bank (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .wr_i   (bus_wr_i),
    .idx_i  (bus_idx),
    .op_i   (bus_op),
    .wdata_i(bus_wdata_i),
    .words_o(store)
  );

  assign cfg0_w   = store[IDX_CFG0];
  assign cfg1_w   = store[IDX_CFG1];
  assign cfg2_w   = store[IDX_CFG2];
  assign mask_w   = store[IDX_MASK];
  assign wake_w   = store[IDX_WAKE];
  assign route_w  = store[IDX_ROUTE];
  assign select_w = store[IDX_SELECT];

  assign rise_clr = (bus_wr_i && bus_op == OP_CLR && bus_idx == IDX_W'(IDX_RISE))
                    ? bus_wdata_i : '0;
  assign fall_clr = (bus_wr_i && bus_op == OP_CLR && bus_idx == IDX_W'(IDX_FALL))
                    ? bus_wdata_i : '0;

  iel_sampler #(.N(NUM_SRC)) u_sample (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .pri_i    (irq_pri_i),
    .alt_i    (irq_alt_i),
    .sel_i    (select_w),
    .lvl_o    (lvl),
    .rise_ev_o(rise_ev),
    .fall_ev_o(fall_ev)
  );

  iel_event #(.N(NUM_SRC)) u_event (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cfg0_i    (cfg0_w),
    .cfg1_i    (cfg1_w),
    .cfg2_i    (cfg2_w),
    .mask_i    (mask_w),
    .wake_i    (wake_w),
    .route_i   (route_w),
    .lvl_i     (lvl),
    .rise_ev_i (rise_ev),
    .fall_ev_i (fall_ev),
    .rise_clr_i(rise_clr),
    .fall_clr_i(fall_clr),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .rise_lat_o(rise_lat),
    .fall_lat_o(fall_lat),
    .active_o  (active),
    .pend0_o   (pend0),
    .pend1_o   (pend1),
    .req0_o    (req0_o),
    .req1_o    (req1_o),
    .wake_o    (wake_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_op == OP_RD) begin
      if (bus_idx < IDX_W'(NUM_STORE)) begin
        bus_rdata_o = store[bus_idx[STORE_W-1:0]];
      end else if (bus_idx == IDX_W'(IDX_RISE)) begin
        bus_rdata_o = rise_lat;
      end else if (bus_idx == IDX_W'(IDX_FALL)) begin
        bus_rdata_o = fall_lat;
      end else if (bus_idx == IDX_W'(IDX_PEND0)) begin
        bus_rdata_o = pend0;
      end else if (bus_idx == IDX_W'(IDX_PEND1)) begin
        bus_rdata_o = pend1;
      end
    end
  end

endmodule

// File: rtl/iel_checks.sv
module iel_checks #(
  parameter int unsigned N = 32
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         req0_o,
  input logic         req1_o,
  input logic         wake_o,
  input logic [N-1:0] pend0,
  input logic [N-1:0] pend1,
  input logic [N-1:0] mask_w,
  input logic [N-1:0] wake_w,
  input logic [N-1:0] active,
  input logic [N-1:0] rise_lat,
  input logic [N-1:0] fall_lat,
  input logic [N-1:0] rise_en,
  input logic [N-1:0] fall_en
);

  assert_rst_quiet_R1: assert property (@(posedge clk_i)
    rst_i |=> (!req0_o && !req1_o && !wake_o));

  assert_req0_follows_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (req0_o == $past(|pend0)));

  assert_req1_follows_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (req1_o == $past(|pend1)));

  assert_wake_unmasked_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> (wake_o == $past(|(active & wake_w))));

  assert_mask_gates_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ((pend0 | pend1) & ~mask_w) == '0);

  assert_rise_needs_mode_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> ((rise_lat & ~$past(rise_lat) & ~$past(rise_en)) == '0));

  assert_fall_needs_mode_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> ((fall_lat & ~$past(fall_lat) & ~$past(fall_en)) == '0));

endmodule

bind irq_edge_level_ctl iel_checks #(.N(NUM_SRC)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .req0_o  (req0_o),
  .req1_o  (req1_o),
  .wake_o  (wake_o),
  .pend0   (pend0),
  .pend1   (pend1),
  .mask_w  (mask_w),
  .wake_w  (wake_w),
  .active  (active),
  .rise_lat(rise_lat),
  .fall_lat(fall_lat),
  .rise_en (rise_en),
  .fall_en (fall_en)
);

// File: tb/sim_irq_edge_level_ctl.sv
`timescale 1ns/1ps
module sim_irq_edge_level_ctl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_wr = 1'b0;
  logic [5:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_pri = '0;
  logic [31:0] b_alt = '0;
  logic [31:0] rdata;
  logic        req0, req1, wake;

  always #2.5 clk = ~clk;

  irq_edge_level_ctl u0 (
    .clk_i(clk), .rst_i(rst), .bus_wr_i(b_wr), .bus_addr_i(b_addr),
    .bus_wdata_i(b_wdata), .bus_rdata_o(rdata), .irq_pri_i(b_pri),
    .irq_alt_i(b_alt), .req0_o(req0), .req1_o(req1), .wake_o(wake)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_reg [8];
  logic [31:0] m_ff1, m_s, m_d, m_rl, m_fl;
  logic        m_r0, m_r1, m_wk;

  function automatic logic [31:0] m_act();
    logic [31:0] a;
    for (int i = 0; i < 32; i++) begin
      case ({m_reg[2][i], m_reg[1][i], m_reg[0][i]})
        3'b001:  a[i] = m_rl[i];
        3'b010:  a[i] = m_fl[i];
        3'b011:  a[i] = m_rl[i] | m_fl[i];
        3'b101:  a[i] = m_s[i];
        3'b110:  a[i] = ~m_s[i];
        default: a[i] = 1'b0;
      endcase
    end
    return a;
  endfunction

  function automatic logic [31:0] m_read(input logic [5:0] a);
    int idx;
    idx = int'(a[5:2]);
    if (a[1:0] != 2'd2) return '0;
    if (idx < 8)   return m_reg[idx];
    if (idx == 8)  return m_rl;
    if (idx == 9)  return m_fl;
    if (idx == 10) return m_act() & m_reg[3] & m_reg[5];
    if (idx == 11) return m_act() & m_reg[3] & ~m_reg[5];
    return '0;
  endfunction

  task automatic m_step();
    logic [31:0] act, rclr, fclr, rev, fev, ren, fen, sel;
    int idx;
    if (rst) begin
      for (int k = 0; k < 8; k++) m_reg[k] = (k == 5 || k == 6) ? '1 : '0;
      m_ff1 = '0; m_s = '0; m_d = '0; m_rl = '0; m_fl = '0;
      m_r0 = 0; m_r1 = 0; m_wk = 0;
      return;
    end
    act  = m_act();
    idx  = int'(b_addr[5:2]);
    rclr = (b_wr && b_addr[1:0] == 2'd1 && idx == 8) ? b_wdata : '0;
    fclr = (b_wr && b_addr[1:0] == 2'd1 && idx == 9) ? b_wdata : '0;
    rev  = m_s & ~m_d;
    fev  = ~m_s & m_d;
    for (int i = 0; i < 32; i++) begin
      logic [2:0] c;
      c = {m_reg[2][i], m_reg[1][i], m_reg[0][i]};
      ren[i] = (c == 3'b001) || (c == 3'b011);
      fen[i] = (c == 3'b010) || (c == 3'b011);
    end
    m_r0 = |(act & m_reg[3] & m_reg[5]);
    m_r1 = |(act & m_reg[3] & ~m_reg[5]);
    m_wk = |(act & m_reg[4]);
    m_rl = (m_rl & ~rclr) | (rev & ren);
    m_fl = (m_fl & ~fclr) | (fev & fen);
    sel  = (b_pri & m_reg[6]) | (b_alt & ~m_reg[6]);
    m_d = m_s; m_s = m_ff1; m_ff1 = sel;
    if (b_wr && idx < 8) begin
      if (b_addr[1:0] == 2'd0) m_reg[idx] = m_reg[idx] | b_wdata;
      else if (b_addr[1:0] == 2'd1) m_reg[idx] = m_reg[idx] & ~b_wdata;
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    m_step();
    #1;
    chk("R2", "rdata vs model", rdata, m_read(b_addr));
    chk("R9/R12", "req0 vs model", {31'b0, req0}, {31'b0, m_r0});
    chk("R8", "req1 vs model", {31'b0, req1}, {31'b0, m_r1});
    chk("R10", "wake vs model", {31'b0, wake}, {31'b0, m_wk});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic wr(input int idx, input int op, input logic [31:0] d);
    b_wr = 1'b1; b_addr = 6'(idx * 4 + op); b_wdata = d;
    cycle();
    b_wr = 1'b0; b_wdata = '0;
  endtask

  task automatic rd(input string tag, input int idx, input logic [31:0] exp);
    b_addr = 6'(idx * 4 + 2);
    #1;
    chk(tag, $sformatf("read word %0d", idx), rdata, exp);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    rst = 1'b1; idle(3); rst = 1'b0; idle(1);
    for (int k = 0; k < 12; k++)
      rd("R1", k, (k == 5 || k == 6) ? 32'hFFFF_FFFF : 32'h0);
    chk("R1", "req0 after reset", {31'b0, req0}, 32'h0);
    chk("R1", "wake after reset", {31'b0, wake}, 32'h0);

    // R2 set / clear / read
    wr(3, 0, 32'hF0); wr(3, 0, 32'h0F); rd("R2", 3, 32'hFF);
    wr(3, 1, 32'h81); rd("R2", 3, 32'h7E);
    wr(3, 0, 32'h0);  rd("R2", 3, 32'h7E);
    wr(3, 2, 32'hFFFF_FFFF); rd("R2", 3, 32'h7E);
    wr(3, 1, 32'hFFFF_FFFF); rd("R2", 3, 32'h0);
    wr(7, 0, 32'hA5); rd("R2", 7, 32'hA5); wr(7, 1, 32'hFFFF_FFFF);
    rd("R2", 13, 32'h0);

    // R4 rising on line 0
    wr(0, 0, 32'h1); wr(3, 0, 32'h1);
    b_pri[0] = 1'b1; idle(5);
    rd("R4", 10, 32'h1); rd("R4", 8, 32'h1);
    chk("R4", "req0 rising", {31'b0, req0}, 32'h1);
    b_pri[0] = 1'b0; idle(5); rd("R4", 10, 32'h1);
    wr(8, 1, 32'h1); idle(2); rd("R6", 10, 32'h0);

    // R4 falling on line 1
    wr(1, 0, 32'h2); wr(3, 0, 32'h2);
    b_pri[1] = 1'b1; idle(5); rd("R4", 10, 32'h0);
    b_pri[1] = 1'b0; idle(5); rd("R4", 10, 32'h2); rd("R4", 9, 32'h2);
    wr(9, 1, 32'h2); idle(2); rd("R6", 10, 32'h0);

    // R4 either edge on line 2
    wr(0, 0, 32'h4); wr(1, 0, 32'h4); wr(3, 0, 32'h4);
    b_pri[2] = 1'b1; idle(5); rd("R4", 10, 32'h4);
    wr(8, 1, 32'h4); idle(2); rd("R4", 10, 32'h0);
    b_pri[2] = 1'b0; idle(5); rd("R4", 10, 32'h4);
    wr(9, 1, 32'h4); idle(2); rd("R4", 10, 32'h0);

    // R5 level modes: line 3 high, line 4 low
    wr(2, 0, 32'h18); wr(0, 0, 32'h8); wr(1, 0, 32'h10); wr(3, 0, 32'h18);
    idle(3); rd("R5", 10, 32'h10);
    b_pri[3] = 1'b1; b_pri[4] = 1'b1; idle(3); rd("R5", 10, 32'h8);
    b_pri[3] = 1'b0; idle(3); rd("R5", 10, 32'h0);

    // R12 latency of a level change
    idle(2);
    b_pri[3] = 1'b1; cycle(); rd("R12", 10, 32'h0);
    cycle(); rd("R12", 10, 32'h8);
    chk("R12", "req0 not yet", {31'b0, req0}, 32'h0);
    cycle(); chk("R12", "req0 one edge later", {31'b0, req0}, 32'h1);

    // R7 mask blocks, config untouched
    wr(3, 1, 32'h8); idle(1); rd("R7", 10, 32'h0); rd("R7", 2, 32'h18);

    // R8 routing to request 1
    wr(5, 1, 32'h8); wr(3, 0, 32'h8); idle(2);
    rd("R8", 11, 32'h8); rd("R8", 10, 32'h0);
    chk("R8", "req1 routed", {31'b0, req1}, 32'h1);
    chk("R8", "req0 idle", {31'b0, req0}, 32'h0);

    // R10 wake ignores mask
    wr(4, 0, 32'h8); wr(3, 1, 32'h8); idle(2);
    chk("R10", "wake with mask off", {31'b0, wake}, 32'h1);
    chk("R10", "req1 masked", {31'b0, req1}, 32'h0);
    wr(4, 1, 32'h8); idle(2);
    chk("R10", "wake cleared", {31'b0, wake}, 32'h0);

    // R3 undefined codes 100 and 111 on lines 5 and 6
    wr(2, 0, 32'h20); wr(0, 0, 32'h40); wr(1, 0, 32'h40); wr(2, 0, 32'h40);
    wr(3, 0, 32'h60);
    b_pri[5] = 1'b1; b_pri[6] = 1'b1; idle(4);
    b_pri[5] = 1'b0; b_pri[6] = 1'b0; idle(4);
    b_pri[5] = 1'b1; idle(4);
    rd("R3", 10, 32'h0); rd("R3", 11, 32'h0); rd("R3", 8, 32'h0); rd("R3", 9, 32'h0);

    // R11 source select on line 7
    wr(2, 0, 32'h80); wr(0, 0, 32'h80); wr(3, 0, 32'h80);
    b_alt[7] = 1'b1; idle(3); rd("R11", 10, 32'h0);
    wr(6, 1, 32'h80); idle(3); rd("R11", 10, 32'h80);
    b_pri[7] = 1'b1; b_alt[7] = 1'b0; idle(3); rd("R11", 10, 32'h0);
    wr(3, 1, 32'h80);

    // R6 edge wins over a same-cycle clear, then clear with mask off
    b_pri[0] = 1'b1; cycle(); cycle();
    wr(8, 1, 32'h1); idle(2);
    rd("R6", 8, 32'h1); rd("R6", 10, 32'h1);
    wr(3, 1, 32'h1); wr(8, 1, 32'h1); idle(2); rd("R6", 8, 32'h0);

    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      b_pri = $urandom(); b_alt = $urandom();
      if (($urandom() % 3) == 0) begin
        b_wr = 1'b1; b_addr = 6'($urandom() % 48); b_wdata = $urandom();
      end else begin
        b_wr = 1'b0; b_addr = 6'(($urandom() % 12) * 4 + 2);
      end
      cycle();
    end
    b_wr = 1'b0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule